// File: doc/BRIEF.md
# Two-Stage Interrupt Pending Controller

The block gathers a vector of interrupt request lines into a sticky source-pending register. Most lines are caught on a rising edge. A few lines come from cascaded groups (external groups, serial-port parents and the converter parent), and these are treated as level requests that set their pending bit again on every cycle the line is high. Two positions are reserved and never go pending. A mask register gates each source. Among the pending, unmasked sources that are not diverted, the lowest index is moved into a one-hot in-service register, which drives the normal interrupt output. A routing register can send one chosen source to a separate fast interrupt output instead.

Software reaches the four registers through a small synchronous bus with a write strobe, a two-bit register select and combinational read data. Software acknowledges a source by first writing a one to its source-pending bit and then writing a one to its in-service bit. If the in-service bit is cleared first, the still-pending source is granted again.

The in-service stage is a two-state machine. In IDLE the register is empty. The GRANT transition (IDLE to SERVICE) loads the lowest candidate, and the WAIT loop keeps the machine in IDLE while no candidate exists. In SERVICE the HOLD loop keeps the granted bit unchanged, whatever else becomes pending. The RELEASE transition (SERVICE to IDLE) fires when a write clears the held bit.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, source-pending (select 0), routing (select 2) and in-service (select 3) read zero, mask (select 1) reads all ones, and both `irq_o` and `fiq_o` are low.
- R2: A source other than a level or reserved one sets its source-pending bit at the clock edge where its input is seen going from 0 to 1. The bit stays set after the input falls, until it is cleared.
- R3: The level sources sit at positions 4, 5, 15, 23, 28 and 31. Each one sets its source-pending bit on every clock edge where its input is high, so a clear written while the input is high does not remove the bit.
- R4: Positions 6 and 24 never become pending, whatever their inputs do.
- R5: A write to select 0 or select 3 clears every bit where the write data is 1, and bits where the data is 0 keep their value. When a set and a clear hit the same source-pending bit in the same cycle, the set wins.
- R6: Mask bit value 1 blocks its source from the in-service register and from `fiq_o`. The source-pending bit is still recorded.
- R7: The in-service register is one-hot or zero. When it is empty, it loads the lowest-index source that is pending, unmasked and not routed, one cycle after that source becomes pending. Once loaded, it holds that bit until a select-3 write clears it.
- R8: `irq_o` is high exactly while the in-service register is nonzero.
- R9: A write to select 2 stores only the lowest set bit of the data, and zero removes all routing. The routed source never enters the in-service register. `fiq_o` is high while that source is pending and unmasked.
- R10: A write to select 1 replaces the mask. Reads return the register named by the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 32 | Interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 source-pending, 1 mask, 2 routing, 3 in-service |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two events can meet in one cycle: a source raising its pending bit, and software clearing that same bit with a one written to select 0. The bench provokes this for an edge source by raising the input and issuing the clearing write on the same clock edge. It provokes it for every level source by clearing while the line is held high. In both cases the bit must read set afterwards. For comparison, the same clear on a held edge source must leave the bit cleared, and the bench computes the expected result from the level map for each of the 32 positions.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_SRCP = 2'd0,
        SEL_MASK = 2'd1,
        SEL_MODE = 2'd2,
        SEL_INTP = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ARB_IDLE    = 1'b0,
        ARB_SERVICE = 1'b1
    } arb_state_e;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int          N         = 32,
    parameter logic [N-1:0] LEVEL_MAP = '0,
    parameter logic [N-1:0] RSVD_MAP  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_q
);
    localparam logic [N-1:0] EDGE_MAP = ~LEVEL_MAP & ~RSVD_MAP;
    localparam logic [N-1:0] LVL_OK   = LEVEL_MAP & ~RSVD_MAP;

    logic [N-1:0] prev_q;
    logic [N-1:0] set_v;

    for (genvar k = 0; k < N; k++) begin : g_src
        if (RSVD_MAP[k]) begin : g_rsvd
            assign set_v[k] = 1'b0;
        end else if (LEVEL_MAP[k]) begin : g_lvl
            assign set_v[k] = src_in[k];
        end else begin : g_edge
            assign set_v[k] = src_in[k] & ~prev_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= src_in;
            pend_q <= (pend_q & ~clr) | set_v;
        end
    end

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_in & ~prev_q & EDGE_MAP) != '0) |=>
        ((pend_q & $past(src_in & ~prev_q & EDGE_MAP)) == $past(src_in & ~prev_q & EDGE_MAP)));

    assert_level_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_in & LVL_OK) != '0) |=>
        ((pend_q & $past(src_in & LVL_OK)) == $past(src_in & LVL_OK)));

    assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set_v) != '0) |=> ((pend_q & $past(clr & ~set_v)) == '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pend_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] route,
    input  logic [N-1:0] clr,
    output logic [N-1:0] intp_q
);
    arb_state_e   state_q, state_d;
    logic [N-1:0] cand;
    logic [N-1:0] lowest;
    logic [N-1:0] intp_d;

    assign cand   = pend & ~mask & ~route;
    assign lowest = cand & (~cand + 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            intp_q  <= '0;
        end else begin
            state_q <= state_d;
            intp_q  <= intp_d;
        end
    end

    always_comb begin
        state_d = state_q;
        intp_d  = intp_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (cand != '0) begin
                    state_d = ARB_SERVICE;
                    intp_d  = lowest;
                end
            end
            ARB_SERVICE: begin
                intp_d = intp_q & ~clr;
                if (intp_d == '0) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    assert_intp_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(intp_q));

    assert_intp_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (intp_q != '0 && (intp_q & clr) == '0) |=> $stable(intp_q));

    assert_grant_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (intp_q != '0 && $past(intp_q) == '0) |-> ((intp_q & $past(cand)) == intp_q));
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int           N         = 32,
    parameter logic [N-1:0] LEVEL_MAP = 32'h9080_8030,
    parameter logic [N-1:0] RSVD_MAP  = 32'h0100_0040
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     src_in,
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic [N-1:0]     bus_wdata,
    output logic [N-1:0]     bus_rdata,
    output logic             irq_o,
    output logic             fiq_o
);
    logic [N-1:0] pend_q, mask_q, mode_q, intp_q;
    logic [N-1:0] clr_src, clr_int;

    assign clr_src = (bus_wr && bus_sel == SEL_SRCP) ? bus_wdata : '0;
    assign clr_int = (bus_wr && bus_sel == SEL_INTP) ? bus_wdata : '0;

    irq_src_latch #(.N(N), .LEVEL_MAP(LEVEL_MAP), .RSVD_MAP(RSVD_MAP)) u_latch (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .clr(clr_src), .pend_q(pend_q)
    );

    irq_arbiter #(.N(N)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(mask_q),
        .route(mode_q), .clr(clr_int), .intp_q(intp_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            mode_q <= '0;
        end else if (bus_wr) begin
            if (bus_sel == SEL_MASK) mask_q <= bus_wdata;
            if (bus_sel == SEL_MODE) mode_q <= bus_wdata & (~bus_wdata + 1'b1);
        end
    end

    always_comb begin
        unique case (reg_sel_e'(bus_sel))
            SEL_SRCP: bus_rdata = pend_q;
            SEL_MASK: bus_rdata = mask_q;
            SEL_MODE: bus_rdata = mode_q;
            SEL_INTP: bus_rdata = intp_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = |intp_q;
    assign fiq_o = |(pend_q & ~mask_q & mode_q);

    assert_mode_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_q));

    assert_rsvd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q | intp_q) & RSVD_MAP) == '0);
endmodule

// File: tb/irq_pend_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_pend_ctrl_tb_top;
    localparam logic [31:0] LVL  = 32'h9080_8030;
    localparam logic [31:0] RSVD = 32'h0100_0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    irq_pend_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        bus_sel = sel;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset values
        rd(2'd0, v); chk("R1 srcp", v, 32'h0);
        rd(2'd1, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R1 mode", v, 32'h0);
        rd(2'd3, v); chk("R1 intp", v, 32'h0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 fiq", {31'd0, fiq_o}, 32'd0);

        wr(2'd1, 32'h0);
        rd(2'd1, v); chk("R10 mask write", v, 32'h0);

        // R2 R3 R4 R7 R8 sweep of single pulses
        for (int i = 0; i < 32; i++) begin
            logic [31:0] b, e;
            b = 32'd1 << i;
            e = RSVD[i] ? 32'h0 : b;
            src_in = b; step();
            rd(2'd0, v); chk("R2/R4 pulse pending", v, e);
            src_in = '0; step();
            rd(2'd0, v); chk("R2 sticky after fall", v, e);
            rd(2'd3, v); chk("R7 grant", v, e);
            chk("R8 irq", {31'd0, irq_o}, {31'd0, e != 0});
            wr(2'd0, b); wr(2'd3, b); step();
            rd(2'd0, v); chk("R5 srcp cleared", v, 32'h0);
            rd(2'd3, v); chk("R5 intp cleared", v, 32'h0);
            chk("R8 irq low", {31'd0, irq_o}, 32'd0);
        end

        // R3 clear while held high: level re-sets, edge stays clear
        for (int i = 0; i < 32; i++) begin
            logic [31:0] b, e;
            b = 32'd1 << i;
            e = (LVL[i] && !RSVD[i]) ? b : 32'h0;
            src_in = b; step(); step();
            wr(2'd0, b);
            rd(2'd0, v); chk("R3 clear while high", v, e);
            src_in = '0; step();
            wr(2'd0, b); wr(2'd3, b); step(); step();
            rd(2'd3, v); chk("R3 cleanup intp", v, 32'h0);
        end

        // R5 same-cycle set and clear on an edge source: set wins
        bus_wr = 1'b1; bus_sel = 2'd0; bus_wdata = 32'h4; src_in = 32'h4;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; src_in = '0;
        rd(2'd0, v); chk("R5 set wins", v, 32'h4);
        wr(2'd0, 32'h4); wr(2'd3, 32'hFFFF_FFFF); step(); step();

        // R7 priority, acknowledge order, hold
        src_in = 32'h208; step(); src_in = '0; step();
        rd(2'd3, v); chk("R7 lowest wins", v, 32'h8);
        wr(2'd3, 32'h8); step();
        rd(2'd3, v); chk("R7 regrant when srcp kept", v, 32'h8);
        wr(2'd0, 32'h8); wr(2'd3, 32'h8); step();
        rd(2'd3, v); chk("R7 next source", v, 32'h200);
        src_in = 32'h2; step(); src_in = '0; step();
        rd(2'd3, v); chk("R7 hold in service", v, 32'h200);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R5 zero write no effect", v, 32'h202);
        wr(2'd3, 32'h0);
        rd(2'd3, v); chk("R5 zero write intp", v, 32'h200);
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF); step(); step();
        rd(2'd3, v); chk("R7 empty after ack", v, 32'h0);

        // R6 mask
        wr(2'd1, 32'h8);
        src_in = 32'h8; step(); src_in = '0; step(); step();
        rd(2'd0, v); chk("R6 masked still pending", v, 32'h8);
        rd(2'd3, v); chk("R6 masked not granted", v, 32'h0);
        chk("R6 irq low", {31'd0, irq_o}, 32'd0);
        wr(2'd1, 32'h0); step();
        rd(2'd3, v); chk("R6 granted after unmask", v, 32'h8);
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF); step();

        // R9 routing
        wr(2'd2, 32'h300);
        rd(2'd2, v); chk("R9 lowest bit kept", v, 32'h100);
        src_in = 32'h100; step(); src_in = '0;
        chk("R9 fiq high", {31'd0, fiq_o}, 32'd1);
        step(); step();
        rd(2'd3, v); chk("R9 routed not in intp", v, 32'h0);
        wr(2'd1, 32'h100);
        chk("R6 fiq masked", {31'd0, fiq_o}, 32'd0);
        wr(2'd1, 32'h0);
        chk("R9 fiq again", {31'd0, fiq_o}, 32'd1);
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk("R9 routing removed", v, 32'h0);
        chk("R9 fiq low", {31'd0, fiq_o}, 32'd0);
        step();
        rd(2'd3, v); chk("R9 unrouted grants", v, 32'h100);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule